// File: doc/BRIEF.md
# FM0 Packet Line Encoder

This block turns a stream of 32-bit command packets into one FM0-coded serial line. Each packet holds up to 26 payload bits in its upper field and, in its low six bits, how many of those bits are meaningful. Packets are taken from the read port of a show-ahead FIFO: the head word is visible while the FIFO is not empty, and a one-cycle read strobe removes it. A pulse on the start input latches the bit period (Tari, given in clock cycles) and begins a command. Packets then flow out back to back until a terminator packet arrives.

The terminator is read and dropped, never sent. The encoder then drives a closing dummy-1 symbol lasting 1.6 Tari and returns the line to its idle level. A done pulse marks the end of the command, and a busy flag covers the whole command.

Top module: `fm0_pkt_encoder`

## Requirements
- R1: A packet carries payload in bits [31:6] and a valid count in bits [5:0]; its valid bits go out most significant first, starting at bit 31, for exactly count bits, and payload bits below the counted ones have no effect on the line.
- R2: A packet whose count is 0 or greater than 26 (the all-zero word included) ends the command; it is removed with one read strobe and puts no data bits on the line.
- R3: Each data bit lasts two halves of floor(Tari/2) cycles each; a 1 keeps the same level in both halves and a 0 changes level between them.
- R4: The line level inverts at the start of every symbol, so the first bit after idle begins low (a 0 is sent low then high).
- R5: The line rests high while no command is active; within a command, consecutive packets that are already in the FIFO are sent with no gap in symbol timing, for Tari of at least 8 cycles.
- R6: After the terminator the line takes the inverse of its last level for floor(Tari*8/5) cycles (the dummy 1) and then goes high.
- R7: The FIFO read strobe is a single-cycle pulse, issued once per packet after its last bit has been taken, and never while the FIFO reports empty.
- R8: Busy is high from the cycle after an accepted start until the command ends; done is a one-cycle pulse in the same cycle that busy falls and the line returns high.
- R9: Start and the Tari input are ignored while busy; Tari is sampled only with an accepted start.
- R10: After reset the line is high and busy, done and the read strobe are low.
- R11: If the FIFO is empty when a command starts, the encoder stays busy with the line high and issues no read until a packet arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a command (one-cycle pulse) |
| tari_i | input | TARI_W | Bit period in clock cycles, sampled with start |
| fifo_data_i | input | 32 | Head word of the packet FIFO |
| fifo_empty_i | input | 1 | FIFO has no words |
| fifo_rd_o | output | 1 | Pop the head word |
| line_o | output | 1 | FM0-coded serial line |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse at end of command |

## Verification
The assertions take the FIFO to be show-ahead and honest: its head word holds until popped, it never reports a word that is not there, and nothing removes words except the read strobe. They also take Tari to be at least 8 cycles. The bench models the FIFO as a simple array with a read pointer advanced only by the strobe. It uses Tari values from 8 to 20 and loads every packet of a command before it is needed, either before start or while the encoder is still waiting on an empty FIFO.

// File: rtl/fm0_pkt_pkg.sv
package fm0_pkt_pkg;

    localparam int PKT_W  = 32;
    localparam int CNT_W  = 6;
    localparam int DATA_W = PKT_W - CNT_W;

    typedef enum logic [2:0] {
        C_WAIT,
        C_START_SEND,
        C_WAIT_SEND,
        C_REQ_DATA,
        C_WAIT_REQ,
        C_WAIT_DUMMY
    } ctrl_state_e;

    // symbol level pairs: first half / second half
    typedef enum logic [1:0] {
        SYM_HH,
        SYM_HL,
        SYM_LH,
        SYM_LL
    } sym_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_FIRST,
        P_SECOND,
        P_DUMMY
    } eng_phase_e;

    function automatic logic sym_first(sym_e s);
        return (s == SYM_HH) || (s == SYM_HL);
    endfunction

    function automatic logic sym_last(sym_e s);
        return (s == SYM_HH) || (s == SYM_LH);
    endfunction

    // next symbol: always starts on the inverse of the previous end level
    function automatic sym_e sym_next(sym_e cur, logic b);
        logic end_lvl;
        end_lvl = sym_last(cur);
        if (b) return end_lvl ? SYM_LL : SYM_HH;
        else   return end_lvl ? SYM_LH : SYM_HL;
    endfunction

    function automatic logic pkt_is_term(logic [PKT_W-1:0] p);
        logic [CNT_W-1:0] c;
        c = p[CNT_W-1:0];
        return (c == '0) || (c > CNT_W'(DATA_W));
    endfunction

endpackage

// File: rtl/fm0_tari_timing.sv
module fm0_tari_timing #(
    parameter int TARI_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TARI_W-1:0] tari_i,
    output logic [TARI_W-1:0] half_len_o,
    output logic [TARI_W:0]   dummy_len_o
);

    localparam int PROD_W = TARI_W + 3;
    localparam int DUM_W  = TARI_W + 1;

    typedef struct packed {
        logic [TARI_W-1:0] half;
        logic [DUM_W-1:0]  dum;
    } tim_t;

    tim_t t_d, t_q;
    logic [PROD_W-1:0] prod;

    always_comb begin
        t_d  = t_q;
        prod = {tari_i, 3'b000};
        if (load_i) begin
            t_d.half = tari_i >> 1;
            t_d.dum  = DUM_W'(prod / PROD_W'(5));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.half <= '0;
            t_q.dum  <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign half_len_o  = t_q.half;
    assign dummy_len_o = t_q.dum;

endmodule

// File: rtl/fm0_symbol_engine.sv
module fm0_symbol_engine
    import fm0_pkt_pkg::*;
#(
    parameter int TARI_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TARI_W-1:0] half_len_i,
    input  logic [TARI_W:0]   dummy_len_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              dummy_req_i,
    output logic              bit_rdy_o,
    output logic              dummy_done_o,
    output logic              line_o
);

    localparam int CW = TARI_W + 1;

    typedef struct packed {
        eng_phase_e    phase;
        sym_e          sym;
        logic          dlvl;
        logic [CW-1:0] cnt;
    } eng_t;

    eng_t e_d, e_q;
    logic [CW-1:0] half_last;
    logic [CW-1:0] dum_last;
    logic          half_end;
    logic          can_start;

    always_comb begin
        e_d          = e_q;
        bit_rdy_o    = 1'b0;
        dummy_done_o = 1'b0;
        half_last    = {1'b0, half_len_i} - CW'(1);
        dum_last     = dummy_len_i - CW'(1);
        half_end     = (e_q.cnt == half_last);
        can_start    = (e_q.phase == P_IDLE) ||
                       ((e_q.phase == P_SECOND) && half_end);

        unique case (e_q.phase)
            P_FIRST: begin
                if (half_end) begin
                    e_d.phase = P_SECOND;
                    e_d.cnt   = '0;
                end else begin
                    e_d.cnt = e_q.cnt + CW'(1);
                end
            end
            P_SECOND: begin
                if (!half_end) e_d.cnt = e_q.cnt + CW'(1);
            end
            P_DUMMY: begin
                if (e_q.cnt == dum_last) begin
                    dummy_done_o = 1'b1;
                    e_d.phase    = P_IDLE;
                    e_d.sym      = SYM_LH;
                    e_d.cnt      = '0;
                end else begin
                    e_d.cnt = e_q.cnt + CW'(1);
                end
            end
            default: ;
        endcase

        if (can_start) begin
            if (bit_vld_i) begin
                bit_rdy_o = 1'b1;
                e_d.sym   = sym_next(e_q.sym, bit_i);
                e_d.phase = P_FIRST;
                e_d.cnt   = '0;
            end else if (dummy_req_i) begin
                e_d.phase = P_DUMMY;
                e_d.dlvl  = ~sym_last(e_q.sym);
                e_d.cnt   = '0;
            end else if (e_q.phase == P_SECOND) begin
                e_d.phase = P_IDLE;
                e_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.phase <= P_IDLE;
            e_q.sym   <= SYM_LH;
            e_q.dlvl  <= 1'b1;
            e_q.cnt   <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    always_comb begin
        unique case (e_q.phase)
            P_FIRST:  line_o = sym_first(e_q.sym);
            P_SECOND: line_o = sym_last(e_q.sym);
            P_DUMMY:  line_o = e_q.dlvl;
            default:  line_o = sym_last(e_q.sym);
        endcase
    end

    // R4: every accepted bit starts with a level inversion
    a_r4_invert_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rdy_o |=> (line_o != $past(line_o)));

    // R3: a bit is only taken when one is offered
    a_r3_take_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rdy_o |-> bit_vld_i);

    // R6: the dummy level holds for its whole length
    a_r6_dummy_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ((e_q.phase == P_DUMMY) && ($past(e_q.phase) == P_DUMMY)) |-> $stable(line_o));

endmodule

// File: rtl/fm0_pkt_ctrl.sv
module fm0_pkt_ctrl
    import fm0_pkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PKT_W-1:0] fifo_data_i,
    input  logic             fifo_empty_i,
    input  logic             bit_rdy_i,
    input  logic             dummy_done_i,
    output logic             fifo_rd_o,
    output logic             tari_load_o,
    output logic             bit_vld_o,
    output logic             bit_o,
    output logic             dummy_req_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        ctrl_state_e       st;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  rem;
        logic              term;
        logic              done;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d         = c_q;
        c_d.done    = 1'b0;
        tari_load_o = 1'b0;

        unique case (c_q.st)
            C_WAIT: begin
                if (start_i) begin
                    tari_load_o = 1'b1;
                    c_d.st      = C_WAIT_REQ;
                end
            end
            C_WAIT_REQ: begin
                if (!fifo_empty_i) begin
                    if (pkt_is_term(fifo_data_i)) begin
                        c_d.term = 1'b1;
                        c_d.st   = C_REQ_DATA;
                    end else begin
                        c_d.sh   = fifo_data_i[PKT_W-1:CNT_W];
                        c_d.rem  = fifo_data_i[CNT_W-1:0];
                        c_d.term = 1'b0;
                        c_d.st   = C_START_SEND;
                    end
                end
            end
            C_START_SEND: c_d.st = C_WAIT_SEND;
            C_WAIT_SEND: begin
                if (bit_rdy_i) begin
                    c_d.sh  = {c_q.sh[DATA_W-2:0], 1'b0};
                    c_d.rem = c_q.rem - CNT_W'(1);
                end
                if (c_q.rem == '0) c_d.st = C_REQ_DATA;
            end
            C_REQ_DATA: c_d.st = c_q.term ? C_WAIT_DUMMY : C_WAIT_REQ;
            C_WAIT_DUMMY: begin
                if (dummy_done_i) begin
                    c_d.st   = C_WAIT;
                    c_d.term = 1'b0;
                    c_d.done = 1'b1;
                end
            end
            default: c_d.st = C_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st   <= C_WAIT;
            c_q.sh   <= '0;
            c_q.rem  <= '0;
            c_q.term <= 1'b0;
            c_q.done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign fifo_rd_o   = (c_q.st == C_REQ_DATA);
    assign bit_vld_o   = (c_q.st == C_WAIT_SEND) && (c_q.rem != '0);
    assign bit_o       = c_q.sh[DATA_W-1];
    assign dummy_req_o = (c_q.st == C_WAIT_DUMMY);
    assign busy_o      = (c_q.st != C_WAIT);
    assign done_o      = c_q.done;

    // R7: never pop an empty FIFO
    a_r7_rd_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> !fifo_empty_i);

    // R7: pop strobe lasts one cycle
    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |=> !fifo_rd_o);

    // R8: done is a single pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/fm0_pkt_encoder.sv
module fm0_pkt_encoder
    import fm0_pkt_pkg::*;
#(
    parameter int TARI_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TARI_W-1:0] tari_i,
    input  logic [31:0]       fifo_data_i,
    input  logic              fifo_empty_i,
    output logic              fifo_rd_o,
    output logic              line_o,
    output logic              busy_o,
    output logic              done_o
);

    logic              tari_load;
    logic [TARI_W-1:0] half_len;
    logic [TARI_W:0]   dummy_len;
    logic              bit_vld;
    logic              bit_val;
    logic              bit_rdy;
    logic              dummy_req;
    logic              dummy_done;

    fm0_pkt_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_empty_i (fifo_empty_i),
        .bit_rdy_i    (bit_rdy),
        .dummy_done_i (dummy_done),
        .fifo_rd_o    (fifo_rd_o),
        .tari_load_o  (tari_load),
        .bit_vld_o    (bit_vld),
        .bit_o        (bit_val),
        .dummy_req_o  (dummy_req),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    fm0_tari_timing #(.TARI_W(TARI_W)) i_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (tari_load),
        .tari_i      (tari_i),
        .half_len_o  (half_len),
        .dummy_len_o (dummy_len)
    );

    fm0_symbol_engine #(.TARI_W(TARI_W)) i_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_len_i   (half_len),
        .dummy_len_i  (dummy_len),
        .bit_vld_i    (bit_vld),
        .bit_i        (bit_val),
        .dummy_req_i  (dummy_req),
        .bit_rdy_o    (bit_rdy),
        .dummy_done_o (dummy_done),
        .line_o       (line_o)
    );

    // R5: line rests high outside a command
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> line_o);

    // R8: done only once the command has ended
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/test_fm0_pkt_encoder.sv
module test_fm0_pkt_encoder;

    typedef struct packed {
        logic [11:0] tari;
        logic [1:0]  npk;
        logic [31:0] p0;
        logic [31:0] p1;
        logic [31:0] p2;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{12'd8,  2'd2, {4'b1011, 22'd0, 6'd4}, 32'h0, 32'h0},
        '{12'd12, 2'd3, {26'h2B4C3A5, 6'd26}, {3'b011, 23'h7FFFFF, 6'd3}, 32'h0},
        '{12'd10, 2'd1, 32'h0, 32'h0, 32'h0},
        '{12'd9,  2'd2, {1'b0, 25'h1FFFFFF, 6'd1}, {26'h155, 6'd27}, 32'h0},
        '{12'd20, 2'd2, {5'b00000, 21'd0, 6'd5}, {26'h3FFFFFF, 6'd63}, 32'h0},
        '{12'd8,  2'd3, {26'h3FFFFFF, 6'd26}, {26'h0, 6'd26}, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] tari_i = 12'd8;
    logic [31:0] fifo_data_i;
    logic        fifo_empty_i;
    logic        fifo_rd_o, line_o, busy_o, done_o;

    logic [31:0] mem [0:63];
    int wp = 0;
    int rp = 0;
    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic exp_lv [0:2047];
    int exp_n;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (fifo_rd_o) rp <= rp + 1;

    assign fifo_data_i  = mem[rp[5:0]];
    assign fifo_empty_i = (rp == wp);

    fm0_pkt_encoder #(.TARI_W(12)) i_fm0_pkt_encoder (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .tari_i (tari_i),
        .fifo_data_i (fifo_data_i), .fifo_empty_i (fifo_empty_i),
        .fifo_rd_o (fifo_rd_o), .line_o (line_o), .busy_o (busy_o), .done_o (done_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic is_term(logic [31:0] p);
        return (p[5:0] == 6'd0) || (p[5:0] > 6'd26);
    endfunction

    // expected per-cycle line levels from the first symbol to the end of the dummy
    task automatic build_exp(input int tari, input int npk, input logic [31:0] pk [3]);
        logic lev;
        int hl, dl;
        logic stop;
        lev = 1'b1; exp_n = 0; stop = 1'b0;
        hl = tari / 2;
        dl = (tari * 8) / 5;
        for (int k = 0; k < npk; k++) begin
            if (!stop) begin
                if (is_term(pk[k])) stop = 1'b1;
                else begin
                    for (int b = 0; b < int'(pk[k][5:0]); b++) begin
                        lev = ~lev;
                        for (int c = 0; c < hl; c++) begin exp_lv[exp_n] = lev; exp_n++; end
                        if (!pk[k][31-b]) lev = ~lev;
                        for (int c = 0; c < hl; c++) begin exp_lv[exp_n] = lev; exp_n++; end
                    end
                end
            end
        end
        lev = ~lev;
        for (int c = 0; c < dl; c++) begin exp_lv[exp_n] = lev; exp_n++; end
    endtask

    // called at a negedge after start was taken; compares the whole command
    task automatic compare_cmd(input string tag, input int rp0, input int npk);
        int t, bad;
        t = 0; bad = 0;
        while (line_o !== 1'b0 && t < 64) begin @(negedge clk); t++; end
        check(t < 64, {"R4 first symbol low ", tag}, t, 0);
        for (int i = 0; i < exp_n; i++) begin
            if (line_o !== exp_lv[i]) bad++;
            if (i == exp_n / 2) begin start_i = 1'b1; tari_i = 12'd40; end
            else begin start_i = 1'b0; tari_i = 12'hFFF; end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(bad == 0, {"R1 R3 R5 R6 R9 waveform ", tag}, bad, 0);
        check(line_o === 1'b1 && done_o === 1'b1 && busy_o === 1'b0,
              {"R8 end of command ", tag}, {line_o, done_o, busy_o}, 3'b110);
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, {"R8 done single ", tag}, done_o, 0);
        check(rp - rp0 == npk, {"R2 R7 packets consumed ", tag}, rp - rp0, npk);
    endtask

    initial begin
        wait (cyc >= 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        logic [31:0] pk [3];
        int rp0;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(line_o === 1'b1, "R10 line", line_o, 1);
        check(busy_o === 1'b0, "R10 busy", busy_o, 0);
        check(done_o === 1'b0, "R10 done", done_o, 0);
        check(fifo_rd_o === 1'b0, "R10 rd", fifo_rd_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            pk[0] = VECS[v].p0; pk[1] = VECS[v].p1; pk[2] = VECS[v].p2;
            rp0 = rp;
            for (int k = 0; k < int'(VECS[v].npk); k++) begin mem[wp[5:0]] = pk[k]; wp++; end
            build_exp(int'(VECS[v].tari), int'(VECS[v].npk), pk);
            start_i = 1'b1; tari_i = VECS[v].tari;
            @(negedge clk);
            start_i = 1'b0; tari_i = 12'hFFF;
            check(busy_o === 1'b1, $sformatf("R8 busy after start v%0d", v), busy_o, 1);
            compare_cmd($sformatf("v%0d", v), rp0, int'(VECS[v].npk));
            repeat (3) @(negedge clk);
        end

        // R11: start with empty FIFO, then supply the packets
        rp0 = rp;
        pk[0] = {1'b1, 25'd0, 6'd1}; pk[1] = 32'h0; pk[2] = 32'h0;
        build_exp(8, 2, pk);
        start_i = 1'b1; tari_i = 12'd8;
        @(negedge clk);
        start_i = 1'b0; tari_i = 12'hFFF;
        repeat (20) @(negedge clk);
        check(line_o === 1'b1 && busy_o === 1'b1, "R11 stall line high busy", {line_o, busy_o}, 2'b11);
        check(rp == rp0, "R11 no read while empty", rp - rp0, 0);
        mem[wp[5:0]] = pk[0]; wp++;
        mem[wp[5:0]] = pk[1]; wp++;
        compare_cmd("stall", rp0, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule